// File: doc/BRIEF.md
# I2C Bus Condition Timing Generator

This block owns the SCL and SDA pull-down enables of an I2C master while the bus enters or leaves a transfer. A single request strobe with a two-bit kind code starts one of three sequences: a START from an idle bus, a repeated START, or a STOP. A STOP is followed by a bus-free gap. Each setup and hold interval is a programmable count of system clocks. The SCL low half-period comes from a baud divider times a pre-scaler. Shifting of data bits is left to a neighbouring engine, which takes over while the bus is held with both lines pulled low.

The block reports a one-cycle completion pulse and a busy level. Busy covers everything from the accepted START to the end of the bus-free gap. Two sticky flags record a finished STOP and a finished repeated START. Each flag is cleared by pulsing its bit on the clear port. A synchronous soft reset drops any sequence, releases both lines and clears the flags.

An output value of 1 on a pull port means the line is driven low. A value of 0 means the line is released. An interval programmed as zero is treated as one clock.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset the block is idle: busy, done, both flags and both pull outputs are 0, and whenever busy is 0 both lines are released.
- R2: A request with kind 0 (START) while not busy pulls SDA low with SCL released for max(start_hold,1) clocks, then pulls SCL low.
- R3: After the START hold, SCL stays low for max(half_div,1)*max(pre_div,1) clocks. Then done pulses for one clock and the bus is held with both lines pulled low.
- R4: Busy rises on the clock that accepts a START and falls on the clock that ends the bus-free gap after a STOP. Done pulses on that same clock.
- R5: Requests are accepted only in two cases: kind 0 while not busy, and kind 1 or 2 while the bus is held after a finished sequence. Everything else is ignored, including any request during a running sequence and kind 3 at any time.
- R6: A request with kind 1 (repeated START) follows a fixed order. SDA is released with SCL low for one half-period. SCL is released for max(rs_setup,1) clocks. SDA is pulled low with SCL high for max(rs_hold,1) clocks. SCL is then pulled low for one half-period, and done pulses.
- R7: A request with kind 2 (STOP) follows a fixed order. SDA is pulled low with SCL low for max(data_setup,1) clocks. SCL is released for max(stop_setup,1) clocks. SDA is released and busy holds for max(bus_free,1) clocks.
- R8: The stop flag rises when SDA is released at the end of a STOP, and the repeated-START flag rises with the done pulse of a repeated START. Writing clr_flags bit 0 clears the stop flag and bit 1 clears the repeated-START flag; each leaves the other flag untouched.
- R9: Every interval programmed as 0 lasts exactly one clock, and so does a half-period with both dividers at 0.
- R10: A soft_rst pulse, even in the middle of a sequence, returns the block to idle on the next clock with both lines released and both flags cleared. A later START then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 START, 1 repeated START, 2 STOP, 3 reserved |
| t_start_hold | input | CW | START hold count |
| t_rs_hold | input | CW | Repeated-START hold count |
| t_rs_setup | input | CW | Repeated-START setup count |
| t_data_setup | input | CW | SDA-low setup count before STOP |
| t_stop_setup | input | CW | STOP setup count |
| t_bus_free | input | CW | Bus-free count after STOP |
| half_div | input | CW | SCL half-period in pre-scaler ticks |
| pre_div | input | CW | Clocks per pre-scaler tick |
| clr_flags | input | 2 | Write-1 clear: bit 0 stop flag, bit 1 repeated-START flag |
| scl_pull | output | 1 | 1 drives SCL low |
| sda_pull | output | 1 | 1 drives SDA low |
| busy | output | 1 | Bus owned, from START to end of bus-free gap |
| done | output | 1 | One-clock completion pulse |
| stop_flag | output | 1 | Sticky STOP-complete flag |
| rs_flag | output | 1 | Sticky repeated-START-complete flag |

## Verification
The bench builds the block with the default 16-bit count width. It runs with distinct small counts for every interval and a half-period of 3 ticks of 2 clocks. Since each interval has a different length, a swapped counter or a miscounted edge shows up as a wrong segment length. A second pass with every count at zero reaches the one-clock floor of each interval and of the half-period.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [CW-1:0] t_start_hold,
  input  logic [CW-1:0] t_rs_hold,
  input  logic [CW-1:0] t_rs_setup,
  input  logic [CW-1:0] t_data_setup,
  input  logic [CW-1:0] t_stop_setup,
  input  logic [CW-1:0] t_bus_free,
  input  logic [CW-1:0] half_div,
  input  logic [CW-1:0] pre_div,
  input  logic [1:0]    clr_flags,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          done,
  output logic          stop_flag,
  output logic          rs_flag
);

  typedef enum logic [3:0] {
    IDLE, S_HOLD, S_LOW, OWN, R_REL, R_SETUP, R_HOLD, R_LOW, P_DSU, P_SETUP, P_FREE
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt, pcnt, ld;
  logic last;

  function automatic logic [CW-1:0] len_m1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic is_half(input st_t s);
    return (s == S_LOW) || (s == R_REL) || (s == R_LOW);
  endfunction

  assign last = (cnt == '0) && (!is_half(st) || pcnt == '0);
  assign busy = (st != IDLE);

  always_comb begin
    nx = st;
    case (st)
      IDLE:    if (req_valid && req_kind == 2'd0) nx = S_HOLD;
      OWN:     if (req_valid && req_kind == 2'd1) nx = R_REL;
               else if (req_valid && req_kind == 2'd2) nx = P_DSU;
      S_HOLD:  if (last) nx = S_LOW;
      S_LOW:   if (last) nx = OWN;
      R_REL:   if (last) nx = R_SETUP;
      R_SETUP: if (last) nx = R_HOLD;
      R_HOLD:  if (last) nx = R_LOW;
      R_LOW:   if (last) nx = OWN;
      P_DSU:   if (last) nx = P_SETUP;
      P_SETUP: if (last) nx = P_FREE;
      P_FREE:  if (last) nx = IDLE;
      default: nx = IDLE;
    endcase
  end

  always_comb begin
    case (nx)
      S_HOLD:               ld = len_m1(t_start_hold);
      S_LOW, R_REL, R_LOW:  ld = len_m1(half_div);
      R_SETUP:              ld = len_m1(t_rs_setup);
      R_HOLD:               ld = len_m1(t_rs_hold);
      P_DSU:                ld = len_m1(t_data_setup);
      P_SETUP:              ld = len_m1(t_stop_setup);
      P_FREE:               ld = len_m1(t_bus_free);
      default:              ld = '0;
    endcase
  end

  always_comb begin
    case (st)
      S_HOLD:                   {scl_pull, sda_pull} = 2'b01;
      S_LOW, OWN, R_LOW, P_DSU: {scl_pull, sda_pull} = 2'b11;
      R_REL:                    {scl_pull, sda_pull} = 2'b10;
      R_HOLD, P_SETUP:          {scl_pull, sda_pull} = 2'b01;
      default:                  {scl_pull, sda_pull} = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; pcnt <= '0;
      done <= 1'b0; stop_flag <= 1'b0; rs_flag <= 1'b0;
    end else if (soft_rst) begin
      st <= IDLE; cnt <= '0; pcnt <= '0;
      done <= 1'b0; stop_flag <= 1'b0; rs_flag <= 1'b0;
    end else begin
      st   <= nx;
      done <= (nx != st) && (nx == OWN || nx == IDLE);
      stop_flag <= (st == P_SETUP && nx == P_FREE) || (stop_flag && !clr_flags[0]);
      rs_flag   <= (st == R_LOW && nx == OWN) || (rs_flag && !clr_flags[1]);
      if (nx != st) begin
        cnt  <= ld;
        pcnt <= len_m1(pre_div);
      end else if (is_half(st)) begin
        if (pcnt == '0) begin
          pcnt <= len_m1(pre_div);
          cnt  <= cnt - 1'b1;
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end else if (st != IDLE && st != OWN) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic [1:0] clr_flags,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       busy,
  input logic       done,
  input logic       stop_flag,
  input logic       rs_flag
);

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  p_start_begin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_kind == 2'd0 && !soft_rst) |=> (busy && sda_pull && !scl_pull));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(soft_rst)) |-> done);

  p_reserved_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_kind == 2'd3 && !soft_rst) |=> !busy);

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> (busy && !scl_pull && !sda_pull));

  p_rs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rs_flag) |-> ($past(clr_flags[1]) || $past(soft_rst)));

  p_soft_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !stop_flag && !rs_flag));

endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_valid(req_valid),
  .req_kind(req_kind), .clr_flags(clr_flags), .scl_pull(scl_pull),
  .sda_pull(sda_pull), .busy(busy), .done(done), .stop_flag(stop_flag),
  .rs_flag(rs_flag)
);

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0, clr_flags = 2'd0;
  logic [CW-1:0] t_sh, t_rh, t_rsu, t_dsu, t_ssu, t_bf, hdiv, pdiv;
  logic scl_pull, sda_pull, busy, done, stop_flag, rs_flag;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  i2c_cond_gen #(.CW(CW)) i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_valid(req_valid),
    .req_kind(req_kind), .t_start_hold(t_sh), .t_rs_hold(t_rh),
    .t_rs_setup(t_rsu), .t_data_setup(t_dsu), .t_stop_setup(t_ssu),
    .t_bus_free(t_bf), .half_div(hdiv), .pre_div(pdiv), .clr_flags(clr_flags),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .stop_flag(stop_flag), .rs_flag(rs_flag)
  );

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int half();
    return eff(hdiv) * eff(pdiv);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic seg(input bit s, input bit d, input int len, input string req);
    int badv = -1;
    for (int i = 0; i < len; i++) begin
      if (badv < 0 && (scl_pull !== s || sda_pull !== d || done !== 1'b0))
        badv = {done, scl_pull, sda_pull};
      @(negedge clk);
    end
    chk(badv < 0, req, badv, {1'b0, s, d});
  endtask

  task automatic req(input logic [1:0] k);
    req_valid = 1'b1; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_start();
    req(2'd0);
    chk(busy === 1'b1, "R4", busy, 1);
    seg(1'b0, 1'b1, eff(t_sh), "R2");
    seg(1'b1, 1'b1, half(), "R3");
    chk(done === 1'b1 && busy === 1'b1 && scl_pull && sda_pull, "R3",
        {done, busy, scl_pull, sda_pull}, 15);
    @(negedge clk);
  endtask

  task automatic do_rstart();
    req(2'd1);
    seg(1'b1, 1'b0, half(), "R6");
    seg(1'b0, 1'b0, eff(t_rsu), "R6");
    seg(1'b0, 1'b1, eff(t_rh), "R6");
    seg(1'b1, 1'b1, half(), "R6");
    chk(done === 1'b1 && rs_flag === 1'b1, "R8", {done, rs_flag}, 3);
    @(negedge clk);
  endtask

  task automatic do_stop();
    req(2'd2);
    seg(1'b1, 1'b1, eff(t_dsu), "R7");
    seg(1'b0, 1'b1, eff(t_ssu), "R7");
    chk(stop_flag === 1'b1 && busy === 1'b1, "R8", {stop_flag, busy}, 3);
    seg(1'b0, 1'b0, eff(t_bf), "R7");
    chk(done === 1'b1 && busy === 1'b0, "R4", {done, busy}, 2);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk({busy, done, stop_flag, rs_flag, scl_pull, sda_pull} === 6'b0, "R1",
        {busy, done, stop_flag, rs_flag, scl_pull, sda_pull}, 0);
  endtask

  task automatic t_clear();
    clr_flags = 2'b01;
    @(negedge clk);
    clr_flags = 2'b00;
    chk(stop_flag === 1'b0 && rs_flag === 1'b1, "R8", {stop_flag, rs_flag}, 1);
    clr_flags = 2'b10;
    @(negedge clk);
    clr_flags = 2'b00;
    chk(rs_flag === 1'b0, "R8", rs_flag, 0);
  endtask

  task automatic t_ignore();
    req(2'd1);
    seg(1'b0, 1'b0, 5, "R5 repeated START while idle");
    chk(busy === 1'b0, "R5", busy, 0);
    req(2'd2);
    seg(1'b0, 1'b0, 5, "R5 STOP while idle");
    req(2'd3);
    seg(1'b0, 1'b0, 5, "R5 reserved while idle");
    do_start();
    req(2'd0);
    seg(1'b1, 1'b1, 5, "R5 START while held");
    req(2'd3);
    seg(1'b1, 1'b1, 5, "R5 reserved while held");
    chk(busy === 1'b1, "R5", busy, 1);
    do_stop();
  endtask

  task automatic t_mid_req();
    req_valid = 1'b1; req_kind = 2'd0;
    @(negedge clk);
    req_kind = 2'd2;
    chk(scl_pull === 1'b0 && sda_pull === 1'b1, "R5 request mid sequence",
        {scl_pull, sda_pull}, 1);
    @(negedge clk);
    req_valid = 1'b0;
    seg(1'b0, 1'b1, eff(t_sh) - 1, "R5 request mid sequence");
    seg(1'b1, 1'b1, half(), "R5 request mid sequence");
    chk(done === 1'b1, "R5", done, 1);
    @(negedge clk);
    do_stop();
  endtask

  task automatic t_soft();
    do_start();
    do_rstart();
    req(2'd2);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk({busy, scl_pull, sda_pull, stop_flag, rs_flag} === 5'b0, "R10",
        {busy, scl_pull, sda_pull, stop_flag, rs_flag}, 0);
    do_start();
    do_stop();
  endtask

  task automatic t_zero();
    t_sh = '0; t_rh = '0; t_rsu = '0; t_dsu = '0; t_ssu = '0; t_bf = '0;
    hdiv = '0; pdiv = '0;
    chk(half() == 1, "R9", half(), 1);
    do_start();
    do_rstart();
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_sh = 16'd3; t_rh = 16'd4; t_rsu = 16'd5; t_dsu = 16'd2;
    t_ssu = 16'd6; t_bf = 16'd7; hdiv = 16'd3; pdiv = 16'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_start();
    do_rstart();
    do_stop();
    t_clear();
    t_ignore();
    t_mid_req();
    t_soft();
    t_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule